// File: doc/BRIEF.md
# PHY Test Pattern Symbol Generator

This block replaces the normal transmit symbol stream of a PHY with one of four fixed test patterns and emits one signed 9-bit symbol per clock cycle. The patterns are a fast square wave that flips sign on every symbol and a slow square wave that flips every ten symbols. The third pattern is a sampled sine tone with a period of 251 samples, whose phase advances by 23 each symbol. The fourth is a constant zero level.

A 3-bit mode code selects the pattern. It is sampled on every clock edge. The sine values are computed while the design is elaborated and held in a lookup table that a phase counter indexes. Whenever the mode code changes, and on the first edge after reset, the selected pattern starts again from its first symbol. A code that names no pattern gives a zero symbol and raises a flag.

Top module: `tpat_symgen`

## Requirements
- R1: While `rst_n` is low, `sym_out` is 0 and `mode_bad` is 0.
- R2: Mode code 2 gives +255, -255, +255, ... and the sign changes on every symbol.
- R3: Mode code 3 gives ten symbols of +255, then ten symbols of -255, with a period of 20 symbols.
- R4: Mode code 4 gives symbol n = round(255·sin(2π·23·n/251)), rounded to the nearest integer, with a period of 251 symbols.
- R5: Mode code 5 gives a constant 0 symbol, and `mode_bad` stays 0.
- R6: Mode codes 0, 1, 6 and 7 give a 0 symbol, with `mode_bad` at 1.
- R7: On the first edge after reset, and on every edge where the mode code differs from its value at the previous edge, the pattern restarts at its first symbol (n = 0).
- R8: The symbol for the mode code sampled at a clock edge appears on `sym_out` immediately after that edge. It passes through one register stage.
- R9: The value of `sym_out` always lies between -255 and +255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Pattern code: 2 fast square, 3 slow square, 4 sine, 5 zero |
| sym_out | output | 9 | Signed transmit symbol |
| mode_bad | output | 1 | High while the sampled code names no pattern |

## Verification
Two events can fall in the same cycle: a change of mode, and a pattern reaching its own wrap or sign-flip point. The slow square is left after exactly ten symbols, at the moment it would flip to -255. The sine is left just past its 251-symbol wrap. Mode 5 is held for a single cycle between two runs of mode 3. In each case the first symbol under the new code must be the start of the new pattern, and must not continue the counter of the old one. A reset applied in the middle of a sine run shows that a restart also takes place when the code does not change.

// File: rtl/tpat_pkg.sv
package tpat_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_FAST = 3'd2;
  localparam logic [MODE_W-1:0] MODE_SLOW = 3'd3;
  localparam logic [MODE_W-1:0] MODE_SINE = 3'd4;
  localparam logic [MODE_W-1:0] MODE_ZERO = 3'd5;

  function automatic logic mode_known(logic [MODE_W-1:0] m);
    return (m == MODE_FAST) || (m == MODE_SLOW) || (m == MODE_SINE) || (m == MODE_ZERO);
  endfunction

  // Amplitude-scaled sine at table index idx, rounded half away from zero.
  function automatic int sine_round(int idx, int period, int amp);
    real ang, r;
    ang = 2.0 * 3.14159265358979 * $itor(idx) / $itor(period);
    r = $itor(amp) * $sin(ang);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(0.5 - r);
  endfunction
endpackage

// File: rtl/tpat_sine_rom.sv
module tpat_sine_rom #(
  parameter int PERIOD = 251,
  parameter int AMP    = 255,
  parameter int SYM_W  = 9,
  parameter int IDX_W  = 8
) (
  input  logic [IDX_W-1:0]        idx,
  output logic signed [SYM_W-1:0] val
);
  import tpat_pkg::*;

  logic signed [SYM_W-1:0] tbl [PERIOD];

  for (genvar i = 0; i < PERIOD; i++) begin : g_ent
    localparam int V = sine_round(i, PERIOD, AMP);
    assign tbl[i] = SYM_W'(V);
  end

  assign val = (int'(idx) < PERIOD) ? tbl[idx] : '0;
endmodule

// File: rtl/tpat_seq.sv
module tpat_seq #(
  parameter int STEP      = 23,
  parameter int PERIOD    = 251,
  parameter int SLOW_HALF = 10,
  parameter int CNT_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [tpat_pkg::MODE_W-1:0] mode_sel,
  output logic                        restart,
  output logic [CNT_W-1:0]            pos
);
  import tpat_pkg::*;

  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(2 * SLOW_HALF - 1);
  localparam logic [CNT_W-1:0] WRAP_AT   = CNT_W'(PERIOD - STEP);
  localparam logic [CNT_W-1:0] STEP_C    = CNT_W'(STEP);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [MODE_W-1:0] mode_q;
  logic              started_q;
  logic [CNT_W-1:0]  cnt_q, nxt;

  assign restart = !started_q || (mode_sel != mode_q);
  assign pos     = restart ? '0 : cnt_q;

  always_comb begin
    case (mode_sel)
      MODE_FAST: nxt = (pos == '0) ? ONE : '0;
      MODE_SLOW: nxt = (pos == SLOW_LAST) ? '0 : pos + ONE;
      MODE_SINE: nxt = (pos >= WRAP_AT) ? pos - WRAP_AT : pos + STEP_C;
      default:   nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      started_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      mode_q    <= mode_sel;
      started_q <= 1'b1;
      cnt_q     <= nxt;
    end
  end
endmodule

// File: rtl/tpat_symgen.sv
module tpat_symgen #(
  parameter int SYM_W       = 9,
  parameter int AMP         = 255,
  parameter int SLOW_HALF   = 10,
  parameter int SINE_PERIOD = 251,
  parameter int SINE_STEP   = 23
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              mode_sel,
  output logic signed [SYM_W-1:0] sym_out,
  output logic                    mode_bad
);
  import tpat_pkg::*;

  localparam int SPAN  = (SINE_PERIOD > 2 * SLOW_HALF) ? SINE_PERIOD : 2 * SLOW_HALF;
  localparam int CNT_W = $clog2(SPAN);
  localparam logic signed [SYM_W-1:0] POS_LVL = SYM_W'(AMP);
  localparam logic signed [SYM_W-1:0] NEG_LVL = -POS_LVL;

  logic                    restart;
  logic [CNT_W-1:0]        pos;
  logic signed [SYM_W-1:0] sine_val, sym_nxt;

  tpat_seq #(.STEP(SINE_STEP), .PERIOD(SINE_PERIOD), .SLOW_HALF(SLOW_HALF), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .restart(restart), .pos(pos)
  );

  tpat_sine_rom #(.PERIOD(SINE_PERIOD), .AMP(AMP), .SYM_W(SYM_W), .IDX_W(CNT_W)) u_rom (
    .idx(pos), .val(sine_val)
  );

  always_comb begin
    case (mode_sel)
      MODE_FAST: sym_nxt = (pos == '0) ? POS_LVL : NEG_LVL;
      MODE_SLOW: sym_nxt = (int'(pos) < SLOW_HALF) ? POS_LVL : NEG_LVL;
      MODE_SINE: sym_nxt = sine_val;
      default:   sym_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_out  <= '0;
      mode_bad <= 1'b0;
    end else begin
      sym_out  <= sym_nxt;
      mode_bad <= !mode_known(mode_sel);
    end
  end
endmodule

// File: rtl/tpat_symgen_chk.sv
module tpat_symgen_chk #(
  parameter int SYM_W     = 9,
  parameter int AMP       = 255,
  parameter int SLOW_HALF = 10,
  parameter int CNT_W     = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [2:0]              mode_sel,
  input logic                    restart,
  input logic [CNT_W-1:0]        pos,
  input logic signed [SYM_W-1:0] sym_out,
  input logic                    mode_bad
);
  assert_fast_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && mode_sel == 3'd2) |=> (sym_out == -$past(sym_out)));

  assert_slow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && mode_sel == 3'd3 && pos != '0 && int'(pos) != SLOW_HALF) |=> $stable(sym_out));

  assert_sine_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && mode_sel == 3'd4) |=> (sym_out == 0));

  assert_zero_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'd5) |=> (sym_out == 0 && !mode_bad));

  assert_bad_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bad |-> (sym_out == 0));

  assert_square_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && (mode_sel == 3'd2 || mode_sel == 3'd3)) |=> (int'(sym_out) == AMP));

  assert_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sym_out) <= AMP && int'(sym_out) >= -AMP));
endmodule

bind tpat_symgen tpat_symgen_chk #(
  .SYM_W(SYM_W), .AMP(AMP), .SLOW_HALF(SLOW_HALF), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .restart(restart),
  .pos(pos), .sym_out(sym_out), .mode_bad(mode_bad)
);

// File: tb/tpat_symgen_bench.sv
`timescale 1ns/1ps
module tpat_symgen_bench;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        mode_sel = 3'd0;
  logic signed [8:0] sym_out;
  logic              mode_bad;
  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tpat_symgen u_tpat_symgen (.clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
                             .sym_out(sym_out), .mode_bad(mode_bad));

  // {mode code, symbols to observe}; neighbours differ so each row is a mode change
  localparam int VEC[12][2] = '{
    '{2, 7}, '{3, 10}, '{4, 256}, '{3, 20}, '{2, 1}, '{5, 6},
    '{6, 4}, '{3, 33}, '{1, 3}, '{4, 40}, '{7, 2}, '{2, 4}};

  function automatic int expect_sym(int m, int n);
    real r;
    case (m)
      2: return (n % 2 == 0) ? 255 : -255;
      3: return ((n % 20) < 10) ? 255 : -255;
      4: begin
        r = 255.0 * $sin(2.0 * 3.14159265358979 * 23.0 * $itor(n) / 251.0);
        return int'($floor(r + 0.5));
      end
      default: return 0;
    endcase
  endfunction

  task automatic check_val(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string req_of(int m);
    case (m)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R6";
    endcase
  endfunction

  // called at a falling edge; each symbol is sampled at the next falling edge
  task automatic run_mode(int m, int len);
    mode_sel = 3'(m);
    for (int i = 0; i < len; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == 0) check_val("R7 R8 first symbol", int'(sym_out), expect_sym(m, 0));
      else check_val(req_of(m), int'(sym_out), expect_sym(m, i));
      check_val({req_of(m), " flag"}, int'(mode_bad), (m >= 2 && m <= 5) ? 0 : 1);
      check_val("R9 range", int'(sym_out > 255 || sym_out < -255), 0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_val("R1 sym", int'(sym_out), 0);
    check_val("R1 flag", int'(mode_bad), 0);
    rst_n = 1'b1;

    foreach (VEC[k]) run_mode(VEC[k][0], VEC[k][1]);

    // reset in the middle of a sine run, then the same code again
    run_mode(4, 17);
    rst_n = 1'b0;
    #1;
    check_val("R1 sym mid-run", int'(sym_out), 0);
    check_val("R1 flag mid-run", int'(mode_bad), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_mode(4, 5);

    // one-cycle glitch to zero mode between slow square runs
    run_mode(3, 4);
    run_mode(5, 1);
    run_mode(3, 12);

    // invalid code right after the fast square, then back
    run_mode(2, 3);
    run_mode(0, 2);
    run_mode(2, 3);

    finish_run();
  end
endmodule